// File: doc/BRIEF.md
# SIMD Lane Divergence Mask Tracker

This block keeps the set of live lanes for one SIMD hardware thread whose lanes may disagree at a conditional branch. The sequencer signals three structured-branch events: an opening conditional that carries a per-lane condition vector, an alternative-path marker, and a closing marker. From these the block produces the live-lane mask that gates the execution lanes. When the lanes split, the lanes whose condition is true run first. The lanes whose condition is false run after the alternative-path marker. The closing marker restores the mask that was live before the conditional opened.

Nested conditionals are held on a LIFO of saved masks, with a parameterised depth. Each entry stores both the mask to restore and the mask for the alternative path. A combinational skip flag tells the sequencer, in the cycle of the event, that the path about to start has no live lane, so the sequencer can jump over it. The lane count `LANES` is set to match the thread's SIMD width (8, 16 or 32). Pushes onto a full stack and pops from an empty one are refused, and each raises a sticky error flag.

Top module: `simd_mask_unit`

## Requirements
- R1: After reset, `live_mask` has every lane set, `nest_depth` is 0, `skip_path` is 0, and both error flags are 0.
- R2: An accepted `if_evt` loads `live_mask & cond` into `live_mask` on the next clock edge and raises `nest_depth` by one.
- R3: When every live lane has its `cond` bit set, `if_evt` leaves `live_mask` unchanged. A following `else_evt` then opens an empty path.
- R4: An accepted `else_evt` loads the mask that was live before the innermost open `if_evt`, ANDed with the inverse of that `if_evt`'s `cond`. `nest_depth` is unchanged.
- R5: An accepted `endif_evt` restores the mask that was live before the innermost open `if_evt` and lowers `nest_depth` by one.
- R6: Up to `DEPTH` conditionals can be open at once. `endif_evt` events restore the saved masks in last-in, first-out order.
- R7: `skip_path` is high, combinationally in the event cycle, exactly when an accepted `if_evt` or `else_evt` would start a path whose mask is all zeros. It is low in every other cycle.
- R8: An `if_evt` while `nest_depth == DEPTH` is ignored: `live_mask` and `nest_depth` stay unchanged. It sets `overflow_err`, which stays set until reset.
- R9: An `else_evt` or `endif_evt` while `nest_depth == 0` is ignored: `live_mask` is unchanged. It sets `underflow_err`, which stays set until reset.
- R10: Events asserted together are resolved by priority: `if_evt` over `else_evt` over `endif_evt`. Only the winning event takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_evt | input | 1 | Opening conditional event |
| else_evt | input | 1 | Alternative-path event |
| endif_evt | input | 1 | Closing event |
| cond | input | LANES | Per-lane branch condition, bit i for lane i |
| live_mask | output | LANES | Lanes enabled for the current instruction |
| skip_path | output | 1 | Path starting this cycle has no live lane |
| nest_depth | output | $clog2(DEPTH+1) | Number of open conditionals |
| overflow_err | output | 1 | Sticky: push attempted on a full stack |
| underflow_err | output | 1 | Sticky: pop attempted on an empty stack |

## Verification
The bench uses 8 lanes and a depth of 4. At a single nesting level it sweeps all 256 condition vectors through if, else and end-if. This separates uniform conditions (all true, all false), where one path is empty and must be flagged, from truly split lanes, where both paths have live lanes and their masks must be complements within the parent. It then fills the stack with distinct conditions and drains it, to show last-in, first-out restoration and the refused push at full depth. It also drives simultaneous events to expose the priority, and runs a long pseudo-random mix of events that covers interleaved nesting, empty pops and error stickiness.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_OPEN  = 2'd1,
    EV_ALT   = 2'd2,
    EV_CLOSE = 2'd3
  } br_evt_e;

  // Fixed priority: opening conditional, then alternative, then closing.
  function automatic br_evt_e pick_evt(input logic open_i, input logic alt_i,
                                       input logic close_i);
    br_evt_e ev;
    if (open_i)       ev = EV_OPEN;
    else if (alt_i)   ev = EV_ALT;
    else if (close_i) ev = EV_CLOSE;
    else              ev = EV_NONE;
    return ev;
  endfunction

endpackage

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 top,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [CW-1:0] count_d;
  logic [CW-1:0] top_idx;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      logic [W-1:0] q;
      logic         we;
      assign we = push && (count == CW'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
      end
      assign slot_q[gi] = q;
    end
  endgenerate

  always_comb begin
    count_d = count;
    if (push)     count_d = count + CW'(1);
    else if (pop) count_d = count - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (push || pop) count <= count_d;
  end

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign top_idx = count - CW'(1);
  assign top     = empty ? '0 : slot_q[top_idx[IW-1:0]];

endmodule

// File: rtl/mask_path_calc.sv
module mask_path_calc
  import simd_mask_pkg::*;
#(
  parameter int LANES = 16
) (
  input  br_evt_e          evt,
  input  logic [LANES-1:0] live,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] top_parent,
  input  logic [LANES-1:0] top_alt,
  input  logic             full,
  input  logic             empty,
  output logic [LANES-1:0] live_d,
  output logic             live_we,
  output logic             push,
  output logic             pop,
  output logic [LANES-1:0] ent_parent,
  output logic [LANES-1:0] ent_alt,
  output logic             skip,
  output logic             ovf_hit,
  output logic             udf_hit
);
  logic [LANES-1:0] taken;

  assign taken      = live & cond;
  assign ent_parent = live;
  assign ent_alt    = live & ~cond;

  always_comb begin
    live_d  = live;
    live_we = 1'b0;
    push    = 1'b0;
    pop     = 1'b0;
    skip    = 1'b0;
    ovf_hit = 1'b0;
    udf_hit = 1'b0;
    unique case (evt)
      EV_OPEN: begin
        if (full) ovf_hit = 1'b1;
        else begin
          push    = 1'b1;
          live_we = 1'b1;
          live_d  = taken;
          skip    = (taken == '0);
        end
      end
      EV_ALT: begin
        if (empty) udf_hit = 1'b1;
        else begin
          live_we = 1'b1;
          live_d  = top_alt;
          skip    = (top_alt == '0);
        end
      end
      EV_CLOSE: begin
        if (empty) udf_hit = 1'b1;
        else begin
          pop     = 1'b1;
          live_we = 1'b1;
          live_d  = top_parent;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/err_flags.sv
module err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_hit,
  input  logic udf_hit,
  output logic ovf_q,
  output logic udf_q
);
  logic ovf_d, udf_d;

  assign ovf_d = ovf_q | ovf_hit;
  assign udf_d = udf_q | udf_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (ovf_hit) ovf_q <= ovf_d;
      if (udf_hit) udf_q <= udf_d;
    end
  end

endmodule

// File: rtl/simd_mask_unit.sv
module simd_mask_unit
  import simd_mask_pkg::*;
#(
  parameter int LANES = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       if_evt,
  input  logic                       else_evt,
  input  logic                       endif_evt,
  input  logic [LANES-1:0]           cond,
  output logic [LANES-1:0]           live_mask,
  output logic                       skip_path,
  output logic [$clog2(DEPTH+1)-1:0] nest_depth,
  output logic                       overflow_err,
  output logic                       underflow_err
);
  localparam int EW = 2 * LANES;

  br_evt_e          evt;
  logic [LANES-1:0] live_d;
  logic             live_we;
  logic             push, pop, full, empty;
  logic [LANES-1:0] ent_parent, ent_alt;
  logic [EW-1:0]    top_ent;
  logic             ovf_hit, udf_hit;

  assign evt = pick_evt(if_evt, else_evt, endif_evt);

  mask_path_calc #(.LANES(LANES)) u_calc (
    .evt        (evt),
    .live       (live_mask),
    .cond       (cond),
    .top_parent (top_ent[EW-1:LANES]),
    .top_alt    (top_ent[LANES-1:0]),
    .full       (full),
    .empty      (empty),
    .live_d     (live_d),
    .live_we    (live_we),
    .push       (push),
    .pop        (pop),
    .ent_parent (ent_parent),
    .ent_alt    (ent_alt),
    .skip       (skip_path),
    .ovf_hit    (ovf_hit),
    .udf_hit    (udf_hit)
  );

  mask_stack #(.W(EW), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata ({ent_parent, ent_alt}),
    .top   (top_ent),
    .count (nest_depth),
    .full  (full),
    .empty (empty)
  );

  err_flags u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_hit (ovf_hit),
    .udf_hit (udf_hit),
    .ovf_q   (overflow_err),
    .udf_q   (underflow_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live_mask <= '1;
    else if (live_we) live_mask <= live_d;
  end

endmodule

// File: rtl/simd_mask_unit_chk.sv
module simd_mask_unit_chk #(
  parameter int LANES = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       if_evt,
  input logic                       else_evt,
  input logic                       endif_evt,
  input logic [LANES-1:0]           cond,
  input logic [LANES-1:0]           live_mask,
  input logic                       skip_path,
  input logic [$clog2(DEPTH+1)-1:0] nest_depth,
  input logic                       overflow_err,
  input logic                       underflow_err
);
  localparam int CW = $clog2(DEPTH + 1);

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= CW'(DEPTH));

  // R2
  open_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_evt && nest_depth != CW'(DEPTH)) |=>
      (live_mask == ($past(live_mask) & $past(cond)) &&
       nest_depth == $past(nest_depth) + CW'(1)));

  // R5
  close_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (endif_evt && !if_evt && !else_evt && nest_depth != '0) |=>
      nest_depth == $past(nest_depth) - CW'(1));

  // R8
  overflow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_evt && nest_depth == CW'(DEPTH)) |=>
      (overflow_err && $stable(live_mask) && $stable(nest_depth)));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);

  // R9
  underflow_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((else_evt || endif_evt) && !if_evt && nest_depth == '0) |=>
      (underflow_err && $stable(live_mask)));

  // R9
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  // R7
  skip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_path |-> (if_evt || else_evt));

  // R4
  alt_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (else_evt && !if_evt) |=> $stable(nest_depth));

endmodule

bind simd_mask_unit simd_mask_unit_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .if_evt        (if_evt),
  .else_evt      (else_evt),
  .endif_evt     (endif_evt),
  .cond          (cond),
  .live_mask     (live_mask),
  .skip_path     (skip_path),
  .nest_depth    (nest_depth),
  .overflow_err  (overflow_err),
  .underflow_err (underflow_err)
);

// File: tb/simd_mask_unit_bench.sv
module simd_mask_unit_bench;
  localparam int L  = 8;
  localparam int D  = 4;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          if_evt, else_evt, endif_evt;
  logic [L-1:0]  cond;
  logic [L-1:0]  live_mask;
  logic          skip_path;
  logic [CW-1:0] nest_depth;
  logic          overflow_err, underflow_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // reference state
  logic [L-1:0] m_live;
  logic [L-1:0] m_par [D];
  logic [L-1:0] m_alt [D];
  int           m_dep;
  logic         m_ovf, m_udf;

  always #4 clk = ~clk;

  simd_mask_unit #(.LANES(L), .DEPTH(D)) u_simd_mask_unit (
    .clk(clk), .rst_n(rst_n), .if_evt(if_evt), .else_evt(else_evt),
    .endif_evt(endif_evt), .cond(cond), .live_mask(live_mask),
    .skip_path(skip_path), .nest_depth(nest_depth),
    .overflow_err(overflow_err), .underflow_err(underflow_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; if_evt = 0; else_evt = 0; endif_evt = 0; cond = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_live = '1; m_dep = 0; m_ovf = 0; m_udf = 0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " live"}, 32'(live_mask), 32'(m_live));
    chk({tag, " depth"}, 32'(nest_depth), 32'(m_dep));
    chk({tag, " R8 ovf"}, 32'(overflow_err), 32'(m_ovf));
    chk({tag, " R9 udf"}, 32'(underflow_err), 32'(m_udf));
  endtask

  task automatic step(input logic i, input logic e, input logic n,
                      input logic [L-1:0] c, input string tag);
    logic exp_skip;
    @(negedge clk);
    if_evt = i; else_evt = e; endif_evt = n; cond = c;
    #1;
    exp_skip = 1'b0;
    if (i) begin
      if (m_dep == D) m_ovf = 1'b1;
      else begin
        m_par[m_dep] = m_live;
        m_alt[m_dep] = m_live & ~c;
        m_live = m_live & c;
        exp_skip = (m_live == '0);
        m_dep++;
      end
    end else if (e) begin
      if (m_dep == 0) m_udf = 1'b1;
      else begin
        m_live = m_alt[m_dep-1];
        exp_skip = (m_live == '0);
      end
    end else if (n) begin
      if (m_dep == 0) m_udf = 1'b1;
      else begin
        m_dep--;
        m_live = m_par[m_dep];
      end
    end
    chk({tag, " R7 skip"}, 32'(skip_path), 32'(exp_skip));
    @(posedge clk); #1;
    if_evt = 0; else_evt = 0; endif_evt = 0;
    check_state(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    do_reset();
    #1;
    // R1 reset state
    chk("R1 live", 32'(live_mask), 32'hFF);
    chk("R1 depth", 32'(nest_depth), 0);
    chk("R1 skip", 32'(skip_path), 0);
    chk("R1 ovf", 32'(overflow_err), 0);
    chk("R1 udf", 32'(underflow_err), 0);

    // R2 R3 R4 R5: every condition vector at one level
    for (int c = 0; c < 256; c++) begin
      step(1, 0, 0, L'(c), "R2 open");
      step(0, 1, 0, '0, "R4 alt");
      step(0, 0, 1, '0, "R5 close");
    end
    // R3 uniform taken keeps mask, alternative flagged empty
    step(1, 0, 0, 8'hFF, "R3 uniform");
    chk("R3 unchanged", 32'(live_mask), 32'hFF);
    @(negedge clk); else_evt = 1; #1;
    chk("R3 empty alt skip", 32'(skip_path), 1);
    @(posedge clk); #1; else_evt = 0; m_live = '0;
    step(0, 0, 1, '0, "R3 close");

    // R6 fill, R8 overflow, drain LIFO
    step(1, 0, 0, 8'b1111_0110, "R6 l1");
    step(1, 0, 0, 8'b0011_1100, "R6 l2");
    step(1, 0, 0, 8'b1110_0111, "R6 l3");
    step(1, 0, 0, 8'b0010_0000, "R6 l4");
    step(1, 0, 0, 8'hFF, "R8 push full");
    step(0, 1, 0, '0, "R6 alt l4");
    for (int k = 0; k < D; k++) step(0, 0, 1, '0, "R6 drain");
    chk("R6 restored", 32'(live_mask), 32'hFF);
    // R9 empty pops
    step(0, 0, 1, '0, "R9 close empty");
    step(0, 1, 0, '0, "R9 alt empty");

    // R10 priority
    do_reset();
    step(1, 0, 1, 8'h0F, "R10 open+close");
    step(0, 1, 1, '0, "R10 alt+close");
    step(1, 1, 1, 8'h03, "R10 all three");
    step(0, 0, 1, '0, "R10 unwind");
    step(0, 0, 1, '0, "R10 unwind");

    // mixed pseudo-random traffic
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] sel;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = lfsr[1:0];
      step(sel == 2'd0 || sel == 2'd3, sel == 2'd1, sel == 2'd2 || lfsr[9],
           lfsr[15:8], "R2 R4 R5 mix");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule